// File: doc/BRIEF.md
# Parallel Flash Command Sequence Controller

This block sits behind a parallel word-wide memory bus with active-low chip-enable, output-enable and write-enable strobes. The strobes, address and write data are brought into the system clock domain through a short synchronizer. Each qualified write pulse becomes one bus write cycle, and a sequencer reads those cycles as multi-cycle unlock commands rather than as direct stores. The recognised commands are word program, chip erase, entry into identification mode and exit from it. Reads return array contents, fixed identification codes, or a status word while an operation is in progress.

Program and erase run on their own timers and raise a busy output while they run. Programming can only clear bits. Erase restores every word to all ones. A program-enable input stands in for the programming supply and must be high for either operation to change the array. The array is a behavioural memory of `2**MEM_AW` words. Bus addresses alias onto it through their low `MEM_AW` bits. Command addresses are compared over the full `ADDR_W` bits.

Top module: `flashCmdCtrl`

## Requirements
- R1: `dataOe` is high only while chip-enable and output-enable are both low and write-enable is high. It is low whenever chip-enable or output-enable is high, and during a write pulse.
- R2: A read returns the word stored at the address modulo `2**MEM_AW`. Every word reads 16'hFFFF after reset.
- R3: The four-cycle sequence AAh@5555h, 55h@2AAAh, A0h@5555h, then D@A stores old AND D at A, so bits only go from 1 to 0. Commands are matched on the low data byte.
- R4: The six-cycle sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h sets every word to 16'hFFFF.
- R5: `busy` is high for exactly `PROG_CYC` clock cycles after a program and exactly `ERASE_CYC` cycles after an erase. A read while busy returns `BUSY_WORD`.
- R6: Bus write cycles that complete while `busy` is high have no effect on the sequencer or the array.
- R7: A write cycle whose address or data does not match the current step returns the sequencer to read mode and leaves the array unchanged.
- R8: A write pulse is not counted while output-enable is low or chip-enable is high.
- R9: A pulse on which chip-enable and write-enable are both low for fewer than `MIN_LOW` clock cycles is not counted as a write cycle.
- R10: A write cycle takes its address when the later of chip-enable and write-enable falls, and its data when the earlier of the two rises.
- R11: After AAh@5555h, 55h@2AAAh, 90h@5555h, reads return `MFR_CODE` at even addresses and `DEV_CODE` at odd addresses. A write with low byte F0h returns reads to the array.
- R12: With `pgmEn` low, program and erase keep their normal busy time but leave the array unchanged.
- R13: After reset `busy` and `dataOe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip-enable strobe, active low |
| oeN | input | 1 | Output-enable strobe, active low |
| weN | input | 1 | Write-enable strobe, active low |
| addr | input | ADDR_W | Bus word address |
| dataIn | input | DATA_W | Bus write data |
| pgmEn | input | 1 | Programming supply present |
| dataOut | output | DATA_W | Read data towards the pad drivers |
| dataOe | output | 1 | Pad driver enable for `dataOut` |
| busy | output | 1 | Self-timed operation in progress |

## Verification
Read results arrive three clock edges after the pins change: two synchronizer stages and then the output register. The bench holds each read for five cycles and samples on the falling clock edge. A write cycle reaches the sequencer three edges after its closing strobe rise, and `busy` rises one edge later. Every write task therefore waits six cycles before the next step. Busy windows are measured by counting high samples from the strobe rise onward. Array checks wait `PROG_CYC` or `ERASE_CYC` plus a margin. Random program traffic is compared against an AND-only model kept in the bench.

// File: rtl/flashSeqPkg.sv
package flashSeqPkg;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PGM, S_ERA3, S_ERA4, S_ERA5
  } seqState_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic loadOp;   // latch program address/data this cycle
    logic doProg;   // commit program word
    logic doErase;  // commit whole-array erase
    logic idMode;   // reads return identification codes
    logic busy;     // timed operation running
  } ctrlStb_t;

  localparam logic [15:0] ADDR_KEY1 = 16'h5555;
  localparam logic [15:0] ADDR_KEY2 = 16'h2AAA;
  localparam logic [7:0]  KEY_A     = 8'hAA;
  localparam logic [7:0]  KEY_B     = 8'h55;
  localparam logic [7:0]  OP_PROG   = 8'hA0;
  localparam logic [7:0]  OP_ERPRE  = 8'h80;
  localparam logic [7:0]  OP_IDENT  = 8'h90;
  localparam logic [7:0]  OP_ERGO   = 8'h10;
  localparam logic [7:0]  OP_EXIT   = 8'hF0;

endpackage

// File: rtl/flashBusSync.sv
module flashBusSync #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int MEM_AW      = 8,
  parameter int MIN_LOW     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic              ceS,
  output logic              oeS,
  output logic              weS,
  output logic [MEM_AW-1:0] rdIdx,
  output logic              wrEv,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);

  localparam int VEC_W = 3 + ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(MIN_LOW + 1) + 1;
  localparam logic [VEC_W-1:0] RST_VEC = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

  logic [VEC_W-1:0] pipe [SYNC_STAGES];
  logic [VEC_W-1:0] rawVec;
  logic [ADDR_W-1:0] addrS;
  logic [DATA_W-1:0] dataS;

  assign rawVec = {ceN, oeN, weN, addr, dataIn};

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) pipe[g] <= RST_VEC;
        else       pipe[g] <= rawVec;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) pipe[g] <= RST_VEC;
        else       pipe[g] <= pipe[g-1];
    end
  end

  assign {ceS, oeS, weS, addrS, dataS} = pipe[SYNC_STAGES-1];
  assign rdIdx = addrS[MEM_AW-1:0];

  // a write cycle is live while both enables are low and output-enable is high
  logic             wrLive;
  logic             wrLiveQ;
  logic [CNT_W-1:0] lowCnt;
  logic [ADDR_W-1:0] addrHold;

  assign wrLive = !ceS && !weS && oeS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrLiveQ  <= 1'b0;
      lowCnt   <= '0;
      addrHold <= '0;
      wrEv     <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      wrLiveQ <= wrLive;
      wrEv    <= 1'b0;
      if (wrLive) begin
        if (!wrLiveQ) begin
          lowCnt   <= CNT_W'(1);
          addrHold <= addrS;          // later falling edge
        end else if (lowCnt < CNT_W'(MIN_LOW)) begin
          lowCnt <= lowCnt + CNT_W'(1);
        end
      end
      if (wrLiveQ && !wrLive && (lowCnt >= CNT_W'(MIN_LOW))) begin
        wrEv   <= 1'b1;
        wrAddr <= addrHold;
        wrData <= dataS;              // earlier rising edge
      end
    end
  end

  // R9: accepted cycles need a closing edge, so two never arrive back to back
  p_ev_spaced_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrEv |=> !wrEv);

endmodule

// File: rtl/flashSeqCtrl.sv
module flashSeqCtrl
  import flashSeqPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEv,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        cmdByte,
  input  logic              pgmEn,
  output ctrlStb_t          stb
);

  localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int TIM_W   = $clog2(MAX_CYC + 1);

  seqState_t        state, nState;
  logic             busyQ, opErase, opEnable, idModeQ;
  logic [TIM_W-1:0] timer;
  logic             accept, isKey1, isKey2;
  logic             startProg, startErase, idSet, idClr;

  assign isKey1 = (wrAddr == ADDR_W'(ADDR_KEY1));
  assign isKey2 = (wrAddr == ADDR_W'(ADDR_KEY2));
  assign accept = wrEv && !busyQ;

  always_comb begin
    nState     = state;
    startProg  = 1'b0;
    startErase = 1'b0;
    idSet      = 1'b0;
    idClr      = 1'b0;
    if (accept) begin
      nState = S_IDLE;
      if (state == S_PGM) begin
        startProg = 1'b1;
      end else if (cmdByte == OP_EXIT) begin
        idClr = 1'b1;
      end else begin
        case (state)
          S_IDLE: if (isKey1 && cmdByte == KEY_A) nState = S_UNL1;
          S_UNL1: if (isKey2 && cmdByte == KEY_B) nState = S_UNL2;
          S_UNL2: begin
            if (isKey1 && cmdByte == OP_PROG)       nState = S_PGM;
            else if (isKey1 && cmdByte == OP_ERPRE) nState = S_ERA3;
            else if (isKey1 && cmdByte == OP_IDENT) idSet = 1'b1;
          end
          S_ERA3: if (isKey1 && cmdByte == KEY_A) nState = S_ERA4;
          S_ERA4: if (isKey2 && cmdByte == KEY_B) nState = S_ERA5;
          S_ERA5: if (isKey1 && cmdByte == OP_ERGO) startErase = 1'b1;
          default: nState = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      busyQ    <= 1'b0;
      opErase  <= 1'b0;
      opEnable <= 1'b0;
      idModeQ  <= 1'b0;
      timer    <= '0;
    end else begin
      state <= nState;
      if (idSet) idModeQ <= 1'b1;
      if (idClr || startProg || startErase) idModeQ <= 1'b0;
      if (startProg || startErase) begin
        busyQ    <= 1'b1;
        opErase  <= startErase;
        opEnable <= pgmEn;
        timer    <= startErase ? TIM_W'(ERASE_CYC - 1) : TIM_W'(PROG_CYC - 1);
      end else if (busyQ) begin
        if (timer == '0) busyQ <= 1'b0;
        else             timer <= timer - TIM_W'(1);
      end
    end
  end

  logic lastCyc;
  assign lastCyc = busyQ && (timer == '0);

  assign stb.loadOp  = startProg;
  assign stb.doProg  = lastCyc && !opErase && opEnable;
  assign stb.doErase = lastCyc && opErase && opEnable;
  assign stb.idMode  = idModeQ;
  assign stb.busy    = busyQ;

  // R6: while busy the sequencer and identification mode are frozen
  p_busy_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |=> ($stable(state) && $stable(idModeQ)));

  // R5: an operation always starts with the sequencer back in read mode
  p_start_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> (state == S_IDLE));

  // R12: a commit only happens on a busy cycle, and busy ends right after it
  p_commit_ends_r12: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doProg || stb.doErase) |=> !busyQ);

endmodule

// File: rtl/flashDatapath.sv
module flashDatapath
  import flashSeqPkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter int          MEM_AW    = 8,
  parameter logic [15:0] MFR_CODE  = 16'h00C3,
  parameter logic [15:0] DEV_CODE  = 16'h00E7,
  parameter logic [15:0] BUSY_WORD = 16'h5A00
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              ceS,
  input  logic              oeS,
  input  logic              weS,
  input  logic [MEM_AW-1:0] rdIdx,
  input  logic [MEM_AW-1:0] wrIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  localparam int DEPTH = 1 << MEM_AW;
  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [MEM_AW-1:0] opIdx;
  logic [DATA_W-1:0] opData;
  logic [DATA_W-1:0] opOld;

  assign opOld = memArr[opIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= ONES;
      opIdx   <= '0;
      opData  <= '0;
      dataOut <= '0;
      dataOe  <= 1'b0;
    end else begin
      if (stb.loadOp) begin
        opIdx  <= wrIdx;
        opData <= wrData;
      end
      if (stb.doErase) begin
        for (int i = 0; i < DEPTH; i++) memArr[i] <= ONES;
      end else if (stb.doProg) begin
        memArr[opIdx] <= opOld & opData;
      end
      dataOe <= !ceS && !oeS && weS;
      if (stb.busy)        dataOut <= DATA_W'(BUSY_WORD);
      else if (stb.idMode) dataOut <= rdIdx[0] ? DATA_W'(DEV_CODE) : DATA_W'(MFR_CODE);
      else                 dataOut <= memArr[rdIdx];
    end
  end

  // R3: programming never sets a bit that was clear
  p_prog_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.doProg |=> ((opOld & ~$past(opOld)) == '0));

  // R4: after an erase commit both ends of the array hold all ones
  p_erase_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.doErase |=> (memArr[0] == ONES && memArr[DEPTH-1] == ONES));

endmodule

// File: rtl/flashCmdCtrl.sv
module flashCmdCtrl
  import flashSeqPkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 16,
  parameter int          MEM_AW      = 8,
  parameter int          MIN_LOW     = 3,
  parameter int          SYNC_STAGES = 2,
  parameter int          PROG_CYC    = 8,
  parameter int          ERASE_CYC   = 64,
  parameter logic [15:0] MFR_CODE    = 16'h00C3,
  parameter logic [15:0] DEV_CODE    = 16'h00E7,
  parameter logic [15:0] BUSY_WORD   = 16'h5A00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              pgmEn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              busy
);

  logic              ceS, oeS, weS, wrEv;
  logic [MEM_AW-1:0] rdIdx;
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;
  ctrlStb_t          stb;

  flashBusSync #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW),
    .MIN_LOW(MIN_LOW), .SYNC_STAGES(SYNC_STAGES)
  ) sync_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .ceS(ceS), .oeS(oeS), .weS(weS),
    .rdIdx(rdIdx), .wrEv(wrEv), .wrAddr(wrAddr), .wrData(wrData)
  );

  flashSeqCtrl #(
    .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEv(wrEv), .wrAddr(wrAddr),
    .cmdByte(wrData[7:0]), .pgmEn(pgmEn), .stb(stb)
  );

  flashDatapath #(
    .DATA_W(DATA_W), .MEM_AW(MEM_AW), .MFR_CODE(MFR_CODE),
    .DEV_CODE(DEV_CODE), .BUSY_WORD(BUSY_WORD)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .ceS(ceS), .oeS(oeS), .weS(weS),
    .rdIdx(rdIdx), .wrIdx(wrAddr[MEM_AW-1:0]), .wrData(wrData),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  assign busy = stb.busy;

endmodule

// File: tb/flashCmdCtrl_tb_top.sv
module flashCmdCtrl_tb_top;

  localparam int          PROG_CYC  = 8;
  localparam int          ERASE_CYC = 64;
  localparam int          MIN_LOW   = 3;
  localparam int          DEPTH     = 256;
  localparam logic [15:0] MFR       = 16'h00C3;
  localparam logic [15:0] DEV       = 16'h00E7;
  localparam logic [15:0] BUSYW     = 16'h5A00;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1, pgmEn = 1'b1;
  logic [15:0] addr = '0, dataIn = '0;
  logic [15:0] dataOut;
  logic dataOe, busy;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [DEPTH];

  always #10 clk = ~clk;

  flashCmdCtrl dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .pgmEn(pgmEn),
    .dataOut(dataOut), .dataOe(dataOe), .busy(busy)
  );

  function automatic logic [15:0] progResult(logic [15:0] oldW, logic [15:0] newW);
    return oldW & newW;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [15:0] d, input int low, input int post);
    @(negedge clk);
    addr = a; dataIn = d; oeN = 1'b1; ceN = 1'b0; weN = 1'b0;
    repeat (low) @(negedge clk);
    weN = 1'b1; ceN = 1'b1;
    repeat (post) @(negedge clk);
  endtask

  task automatic readWord(input logic [15:0] a, output logic [15:0] d, output logic oe);
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    repeat (5) @(negedge clk);
    d = dataOut; oe = dataOe;
    ceN = 1'b1; oeN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic countBusy(input int maxCyc, output int n);
    n = 0;
    for (int i = 0; i < maxCyc; i++) begin
      @(negedge clk);
      if (busy) n++;
    end
  endtask

  task automatic unlock3(input logic [7:0] op);
    busWrite(16'h5555, 16'h00AA, 4, 6);
    busWrite(16'h2AAA, 16'h0055, 4, 6);
    busWrite(16'h5555, {8'h00, op}, 4, 6);
  endtask

  task automatic progSeq(input logic [15:0] a, input logic [15:0] d);
    unlock3(8'hA0);
    busWrite(a, d, 4, PROG_CYC + 6);
    if (pgmEn) model[a[7:0]] = progResult(model[a[7:0]], d);
  endtask

  task automatic eraseFront;
    unlock3(8'h80);
    busWrite(16'h5555, 16'h00AA, 4, 6);
    busWrite(16'h2AAA, 16'h0055, 4, 6);
  endtask

  task automatic modelErase;
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] rd;
    logic oe;
    int n;
    modelErase();
    void'($urandom(32'h00C0FFEE));
    repeat (4) @(negedge clk);
    // R13 reset state
    chk(busy == 1'b0, "R13 busy after reset", {15'd0, busy}, 16'h0);
    chk(dataOe == 1'b0, "R13 dataOe in reset", {15'd0, dataOe}, 16'h0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && dataOe == 1'b0, "R13 idle after release", {14'd0, busy, dataOe}, 16'h0);

    // R1 / R2 read path
    readWord(16'h0040, rd, oe);
    chk(oe == 1'b1, "R1 driven on read", {15'd0, oe}, 16'h1);
    chk(rd == 16'hFFFF, "R2 erased word after reset", rd, 16'hFFFF);
    @(negedge clk); ceN = 1'b1; oeN = 1'b0; repeat (5) @(negedge clk);
    chk(dataOe == 1'b0, "R1 chip-enable high", {15'd0, dataOe}, 16'h0);
    ceN = 1'b0; oeN = 1'b1; repeat (5) @(negedge clk);
    chk(dataOe == 1'b0, "R1 output-enable high", {15'd0, dataOe}, 16'h0);
    ceN = 1'b0; oeN = 1'b0; weN = 1'b0; repeat (5) @(negedge clk);
    chk(dataOe == 1'b0, "R1 write-enable low", {15'd0, dataOe}, 16'h0);
    ceN = 1'b1; oeN = 1'b1; weN = 1'b1; repeat (5) @(negedge clk);

    // R3 program and AND behaviour
    progSeq(16'h0040, 16'h0F0F);
    readWord(16'h0040, rd, oe);
    chk(rd == 16'h0F0F, "R3 first program", rd, 16'h0F0F);
    progSeq(16'h0040, 16'hF0FF);
    readWord(16'h0040, rd, oe);
    chk(rd == model[8'h40], "R3 only clears bits", rd, model[8'h40]);
    readWord(16'h0140, rd, oe);
    chk(rd == model[8'h40], "R2 address alias", rd, model[8'h40]);

    // R5 program busy length
    unlock3(8'hA0);
    busWrite(16'h0041, 16'h1234, 4, 0);
    countBusy(PROG_CYC + 12, n);
    model[8'h41] = progResult(model[8'h41], 16'h1234);
    chk(n == PROG_CYC, "R5 program busy cycles", 16'(n), 16'(PROG_CYC));
    readWord(16'h0041, rd, oe);
    chk(rd == 16'h1234, "R5 program result", rd, 16'h1234);

    // R7 mismatch aborts
    busWrite(16'h5555, 16'h00AA, 4, 6);
    busWrite(16'h2AAA, 16'h0055, 4, 6);
    busWrite(16'h5555, 16'h0077, 4, 6);
    busWrite(16'h0042, 16'h0000, 4, PROG_CYC + 6);
    readWord(16'h0042, rd, oe);
    chk(rd == 16'hFFFF, "R7 wrong command byte", rd, 16'hFFFF);
    busWrite(16'h5555, 16'h00AA, 4, 6);
    busWrite(16'h1111, 16'h0055, 4, 6);
    busWrite(16'h5555, 16'h00A0, 4, 6);
    busWrite(16'h0042, 16'h0000, 4, PROG_CYC + 6);
    readWord(16'h0042, rd, oe);
    chk(rd == 16'hFFFF, "R7 wrong unlock address", rd, 16'hFFFF);

    // R8 inhibited pulse, then a real one completes the program
    unlock3(8'hA0);
    @(negedge clk); addr = 16'h0043; dataIn = 16'h0000; oeN = 1'b0; ceN = 1'b0; weN = 1'b0;
    repeat (5) @(negedge clk); weN = 1'b1; ceN = 1'b1; oeN = 1'b1;
    repeat (PROG_CYC + 6) @(negedge clk);
    @(negedge clk); ceN = 1'b1; weN = 1'b0;
    repeat (5) @(negedge clk); weN = 1'b1;
    repeat (PROG_CYC + 6) @(negedge clk);
    readWord(16'h0043, rd, oe);
    chk(rd == 16'hFFFF && busy == 1'b0, "R8 inhibited write", rd, 16'hFFFF);
    // R9 short pulse ignored, sequencer still waiting for data
    busWrite(16'h0043, 16'h0000, MIN_LOW - 1, PROG_CYC + 6);
    readWord(16'h0043, rd, oe);
    chk(rd == 16'hFFFF, "R9 glitch ignored", rd, 16'hFFFF);
    busWrite(16'h0043, 16'h00FF, MIN_LOW, PROG_CYC + 6);
    model[8'h43] = 16'h00FF;
    readWord(16'h0043, rd, oe);
    chk(rd == 16'h00FF, "R9 minimum pulse accepted", rd, 16'h00FF);

    // R10 address at later fall, data at earlier rise
    unlock3(8'hA0);
    @(negedge clk); oeN = 1'b1; addr = 16'h0050; dataIn = 16'h0000; weN = 1'b0;
    repeat (3) @(negedge clk); addr = 16'h0051; ceN = 1'b0;
    repeat (3) @(negedge clk); addr = 16'h0052; dataIn = 16'hAAAA;
    repeat (3) @(negedge clk); dataIn = 16'h3C3C;
    repeat (3) @(negedge clk); ceN = 1'b1;
    repeat (3) @(negedge clk); dataIn = 16'h0000; weN = 1'b1;
    repeat (PROG_CYC + 8) @(negedge clk);
    model[8'h51] = 16'h3C3C;
    readWord(16'h0051, rd, oe);
    chk(rd == 16'h3C3C, "R10 captured address and data", rd, 16'h3C3C);
    readWord(16'h0050, rd, oe);
    chk(rd == 16'hFFFF, "R10 early address unused", rd, 16'hFFFF);
    readWord(16'h0052, rd, oe);
    chk(rd == 16'hFFFF, "R10 late address unused", rd, 16'hFFFF);

    // R11 identification mode
    unlock3(8'h90);
    readWord(16'h0000, rd, oe);
    chk(rd == MFR, "R11 manufacturer code", rd, MFR);
    readWord(16'h0001, rd, oe);
    chk(rd == DEV, "R11 device code", rd, DEV);
    busWrite(16'h0000, 16'h00F0, 4, 6);
    readWord(16'h0041, rd, oe);
    chk(rd == model[8'h41], "R11 exit returns array", rd, model[8'h41]);

    // R12 programming supply absent
    pgmEn = 1'b0;
    unlock3(8'hA0);
    busWrite(16'h0041, 16'h0000, 4, 0);
    countBusy(PROG_CYC + 12, n);
    chk(n == PROG_CYC, "R12 busy time kept", 16'(n), 16'(PROG_CYC));
    readWord(16'h0041, rd, oe);
    chk(rd == model[8'h41], "R12 program blocked", rd, model[8'h41]);
    eraseFront();
    busWrite(16'h5555, 16'h0010, 4, ERASE_CYC + 8);
    readWord(16'h0040, rd, oe);
    chk(rd == model[8'h40], "R12 erase blocked", rd, model[8'h40]);
    pgmEn = 1'b1;

    // R4 / R5 erase with busy count
    eraseFront();
    busWrite(16'h5555, 16'h0010, 4, 0);
    countBusy(ERASE_CYC + 12, n);
    modelErase();
    chk(n == ERASE_CYC, "R5 erase busy cycles", 16'(n), 16'(ERASE_CYC));
    readWord(16'h0040, rd, oe);
    chk(rd == 16'hFFFF, "R4 erased word", rd, 16'hFFFF);
    readWord(16'h0051, rd, oe);
    chk(rd == 16'hFFFF, "R4 erased second word", rd, 16'hFFFF);

    // R5 status read and R6 writes ignored while busy
    eraseFront();
    busWrite(16'h5555, 16'h0010, 4, 1);
    readWord(16'h0060, rd, oe);
    chk(rd == BUSYW, "R5 status while busy", rd, BUSYW);
    unlock3(8'hA0);
    chk(busy == 1'b1, "R6 still busy during writes", {15'd0, busy}, 16'h1);
    for (int i = 0; i < ERASE_CYC && busy; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    busWrite(16'h0077, 16'h0000, 4, PROG_CYC + 6);
    readWord(16'h0077, rd, oe);
    chk(rd == 16'hFFFF, "R6 busy writes dropped", rd, 16'hFFFF);

    // random program traffic against the model
    for (int k = 0; k < 24; k++) begin
      logic [15:0] ra, rdat;
      ra = 16'($urandom());
      rdat = 16'($urandom());
      if (ra == 16'h5555 || ra == 16'h2AAA) ra = ra ^ 16'h0100;
      progSeq(ra, rdat);
      readWord(ra, rd, oe);
      chk(rd == model[ra[7:0]], "R3 random program", rd, model[ra[7:0]]);
    end
    for (int k = 0; k < 12; k++) begin
      logic [15:0] ra;
      ra = 16'($urandom());
      readWord(ra, rd, oe);
      chk(rd == model[ra[7:0]] && oe, "R2 random read", rd, model[ra[7:0]]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule